// File: doc/BRIEF.md
# Four-Lane Receive Deskew Aligner

This block sits after the per-lane word aligners and 8b/10b decoders of a four-lane 10 Gb/s attachment-unit receiver. Each lane presents one decoded character per clock: a byte, a control (K) flag and that lane's "synchronized" status. The lanes can reach the block at different times, so a column that the far end sent at one moment can arrive on different clocks. The block puts them back together. It holds each lane in a small buffer, starting at the first alignment character (||A||, the K28.3 control code) that the lane shows. When every lane has an alignment character at the front of its buffer, it releases all buffers together. From then on each output column holds the characters that were sent side by side.

The block does nothing until every lane reports synchronization. A lane losing sync sends it back to that waiting state. Once the lanes are aligned, the block watches each released column. An alignment character on some lanes but not on the others means the lanes have slipped. A run of such columns clears the deskew status, and the block hunts for alignment again. The status output tells the next stage, which does rate matching and recovery of the media-independent interface, when the released columns can be trusted.

Top module: `lane_deskew_aligner`

## Requirements
- R1: While any bit of `rx_synced` is 0, input characters are not buffered, `deskew_ok` stays 0 and `col_valid` stays 0, even when every lane is sending alignment characters.
- R2: Only byte 0x7C with the K flag at 1 counts as an alignment character. Byte 0x7C with K at 0, and other K codes such as 0xBC, do not start a lane and never lead to alignment.
- R3: Each lane drops its characters until it sees its first alignment character. After alignment, `col_valid` is 1 on every clock. The columns come out in the order they were sent, starting with the alignment column. Lane i occupies `col_data[8i+7:8i]` and `col_is_k[i]`.
- R4: `deskew_ok` rises only when every lane holds an alignment character at the front of its buffer. It is already 1 on the clock before the first released column appears on `col_valid`.
- R5: Alignment succeeds for any skew between lanes of up to FIFO_DEPTH-2 clocks (6 with the default depth of 8).
- R6: If a lane buffer fills before the other lanes have started, all buffers are discarded. The block then waits for a later alignment character. With a single alignment character and a skew of FIFO_DEPTH-1, it never aligns.
- R7: When any lane loses sync while aligned, `deskew_ok` is 0 on the next clock, `col_valid` is 0 on the clock after that, and the buffered characters are discarded.
- R8: While aligned, a released column with alignment characters on some lanes but not all is an alignment error. A column with an alignment character on every lane resets the error count. A column with none leaves the count unchanged. The ERR_LIMIT-th consecutive error (4 by default) is still released, then `deskew_ok` falls and hunting restarts.
- R9: After reset all outputs are 0, and `col_valid` is 1 only on a clock after one where `deskew_ok` was 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_data | input | NUM_LANES*8 | Decoded byte of each lane, lane i at bits 8i+7:8i |
| rx_is_k | input | NUM_LANES | Control flag of each lane's byte |
| rx_synced | input | NUM_LANES | Per-lane word-alignment lock status |
| col_data | output | NUM_LANES*8 | Deskewed column bytes, lane i at bits 8i+7:8i |
| col_is_k | output | NUM_LANES | Control flags of the deskewed column |
| col_valid | output | 1 | A deskewed column is present this clock |
| deskew_ok | output | 1 | Lanes are aligned |

## Verification
A buffer pointer or occupancy that is wrong for one lane shows up at the ports as a shifted column. The column released after alignment then no longer matches what was sent. The scoreboard sees this on the first such column, at most a few clocks after `deskew_ok` rises. Errors in the state machine or the error counter show as `deskew_ok` being held or dropped on the wrong clock: too early, too late, or never. They also show as released columns that are unexpected or missing. The bench compares the number of released columns with the exact count that R7 and R8 allow. A fault in marker detection gives an output stream that starts at the wrong column, or never starts.

// File: rtl/dsk_pkg.sv
package dsk_pkg;

   typedef enum logic [1:0] {
      DSK_WAIT_SYNC = 2'd0,
      DSK_HUNT      = 2'd1,
      DSK_ALIGNED   = 2'd2
   } dsk_state_e;

   typedef struct packed {
      logic       is_k;
      logic [7:0] byte_val;
   } dsk_char_t;

   localparam int DSK_BYTE_W = 8;

endpackage

// File: rtl/dsk_lane_fifo.sv
module dsk_lane_fifo
   import dsk_pkg::*;
#(
   parameter int DEPTH = 8
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      flush,
   input  logic      push,
   input  logic      pop,
   input  dsk_char_t wr_char,
   output dsk_char_t head,
   output logic      empty,
   output logic      full
);

   localparam int  PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int  CNT_W = $clog2(DEPTH + 1);
   localparam bit  IS_POW2 = ((DEPTH & (DEPTH - 1)) == 0);

   generate
      if (DEPTH < 4) begin : g_depth_too_small
         $error("dsk_lane_fifo: DEPTH must be at least 4");
      end
   endgenerate

   dsk_char_t        mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr;
   logic [PTR_W-1:0] wr_ptr_nxt, rd_ptr_nxt;
   logic [CNT_W-1:0] count;
   logic             do_push, do_pop;

   // pointer advance: free wrap for power-of-two depth, compare otherwise
   generate
      if (IS_POW2) begin : g_wrap_pow2
         assign wr_ptr_nxt = wr_ptr + PTR_W'(1);
         assign rd_ptr_nxt = rd_ptr + PTR_W'(1);
      end else begin : g_wrap_cmp
         assign wr_ptr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
         assign rd_ptr_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
      end
   endgenerate

   assign empty   = (count == '0);
   assign full    = (count == CNT_W'(DEPTH));
   assign do_pop  = pop && !empty;
   assign do_push = push && (!full || do_pop);
   assign head    = mem[rd_ptr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr_nxt;
         if (do_pop)  rd_ptr <= rd_ptr_nxt;
         case ({do_push, do_pop})
            2'b10:   count <= count + CNT_W'(1);
            2'b01:   count <= count - CNT_W'(1);
            default: count <= count;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (do_push && !flush) begin
         mem[wr_ptr] <= wr_char;
      end
   end

   // R6
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop) |-> flush);

   // R3
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !flush) |-> !empty);

endmodule

// File: rtl/dsk_marker_detect.sv
module dsk_marker_detect
   import dsk_pkg::*;
#(
   parameter int         NUM_LANES   = 4,
   parameter logic [7:0] MARKER_CODE = 8'h7C
) (
   input  dsk_char_t [NUM_LANES-1:0] chars,
   output logic      [NUM_LANES-1:0] hit,
   output logic                      any_hit,
   output logic                      all_hit
);

   generate
      for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane_match
         assign hit[g] = chars[g].is_k && (chars[g].byte_val == MARKER_CODE);
      end
   endgenerate

   assign any_hit = |hit;
   assign all_hit = &hit;

endmodule

// File: rtl/dsk_align_ctrl.sv
module dsk_align_ctrl
   import dsk_pkg::*;
#(
   parameter int NUM_LANES = 4,
   parameter int ERR_LIMIT = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 all_synced,
   input  logic [NUM_LANES-1:0] lane_empty,
   input  logic [NUM_LANES-1:0] lane_full,
   input  logic [NUM_LANES-1:0] lane_push,
   input  logic                 head_any,
   input  logic                 head_all,
   output logic                 aligned,
   output logic                 capture_en,
   output logic                 flush,
   output logic                 pop
);

   localparam int ERR_W = $clog2(ERR_LIMIT + 1);

   generate
      if (ERR_LIMIT < 1) begin : g_bad_limit
         $error("dsk_align_ctrl: ERR_LIMIT must be at least 1");
      end
   endgenerate

   dsk_state_e       state, state_nxt;
   logic [ERR_W-1:0] err_cnt;
   logic             all_started;
   logic             overflow;
   logic             partial;
   logic             err_final;

   assign all_started = ~|lane_empty;
   assign pop         = (state == DSK_ALIGNED);
   assign overflow    = (|(lane_full & lane_push)) && !pop;
   assign partial     = head_any && !head_all;
   assign err_final   = partial && (err_cnt == ERR_W'(ERR_LIMIT - 1));
   assign aligned     = (state == DSK_ALIGNED);
   assign capture_en  = all_synced && (state != DSK_WAIT_SYNC);

   always_comb begin
      state_nxt = state;
      if (!all_synced) begin
         state_nxt = DSK_WAIT_SYNC;
      end else begin
         case (state)
            DSK_WAIT_SYNC: state_nxt = DSK_HUNT;
            DSK_HUNT: begin
               if (overflow)         state_nxt = DSK_HUNT;
               else if (all_started) state_nxt = DSK_ALIGNED;
            end
            DSK_ALIGNED: begin
               if (err_final) state_nxt = DSK_HUNT;
            end
            default: state_nxt = DSK_WAIT_SYNC;
         endcase
      end
   end

   always_comb begin
      flush = 1'b0;
      if (!all_synced)                           flush = 1'b1;
      else if (state == DSK_WAIT_SYNC)           flush = 1'b1;
      else if (state == DSK_HUNT && overflow)    flush = 1'b1;
      else if (state == DSK_ALIGNED && err_final) flush = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= DSK_WAIT_SYNC;
      else        state <= state_nxt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_cnt <= '0;
      end else if (state != DSK_ALIGNED || head_all || err_final) begin
         err_cnt <= '0;
      end else if (partial) begin
         err_cnt <= err_cnt + ERR_W'(1);
      end
   end

   // R1
   sync_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !all_synced |=> !aligned);

   // R4
   marker_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(aligned) |-> $past(head_all));

   // R5
   aligned_filled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      aligned |-> all_started);

   // R8
   err_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (aligned && head_any && !head_all && err_cnt == ERR_W'(ERR_LIMIT - 1)) |=> !aligned);

endmodule

// File: rtl/dsk_out_stage.sv
module dsk_out_stage
   import dsk_pkg::*;
#(
   parameter int NUM_LANES = 4
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              load,
   input  dsk_char_t [NUM_LANES-1:0]         heads,
   output logic      [NUM_LANES*DSK_BYTE_W-1:0] out_data,
   output logic      [NUM_LANES-1:0]         out_is_k,
   output logic                              out_valid
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_data  <= '0;
         out_is_k  <= '0;
         out_valid <= 1'b0;
      end else begin
         out_valid <= load;
         if (load) begin
            for (int i = 0; i < NUM_LANES; i++) begin
               out_data[i*DSK_BYTE_W +: DSK_BYTE_W] <= heads[i].byte_val;
               out_is_k[i]                          <= heads[i].is_k;
            end
         end
      end
   end

endmodule

// File: rtl/lane_deskew_aligner.sv
module lane_deskew_aligner
   import dsk_pkg::*;
#(
   parameter int         NUM_LANES   = 4,
   parameter int         FIFO_DEPTH  = 8,
   parameter int         ERR_LIMIT   = 4,
   parameter logic [7:0] MARKER_CODE = 8'h7C
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NUM_LANES*8-1:0] rx_data,
   input  logic [NUM_LANES-1:0]   rx_is_k,
   input  logic [NUM_LANES-1:0]   rx_synced,
   output logic [NUM_LANES*8-1:0] col_data,
   output logic [NUM_LANES-1:0]   col_is_k,
   output logic                   col_valid,
   output logic                   deskew_ok
);

   generate
      if (NUM_LANES < 2) begin : g_bad_lanes
         $error("lane_deskew_aligner: NUM_LANES must be at least 2");
      end
   endgenerate

   dsk_char_t [NUM_LANES-1:0] in_chars;
   dsk_char_t [NUM_LANES-1:0] head_chars;
   logic      [NUM_LANES-1:0] in_hit, head_hit;
   logic      [NUM_LANES-1:0] lane_empty, lane_full, lane_push;
   logic                      in_any, in_all, head_any, head_all;
   logic                      all_synced, capture_en, flush, pop, aligned;

   assign all_synced = &rx_synced;

   dsk_marker_detect #(
      .NUM_LANES  (NUM_LANES),
      .MARKER_CODE(MARKER_CODE)
   ) u_in_detect (
      .chars  (in_chars),
      .hit    (in_hit),
      .any_hit(in_any),
      .all_hit(in_all)
   );

   dsk_marker_detect #(
      .NUM_LANES  (NUM_LANES),
      .MARKER_CODE(MARKER_CODE)
   ) u_head_detect (
      .chars  (head_chars),
      .hit    (head_hit),
      .any_hit(head_any),
      .all_hit(head_all)
   );

   generate
      for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
         assign in_chars[g].is_k     = rx_is_k[g];
         assign in_chars[g].byte_val = rx_data[g*8 +: 8];
         // a lane starts filling on its first marker, then takes every character
         assign lane_push[g] = capture_en && (!lane_empty[g] || in_hit[g]);

         dsk_lane_fifo #(
            .DEPTH(FIFO_DEPTH)
         ) u_fifo (
            .clk    (clk),
            .rst_n  (rst_n),
            .flush  (flush),
            .push   (lane_push[g]),
            .pop    (pop),
            .wr_char(in_chars[g]),
            .head   (head_chars[g]),
            .empty  (lane_empty[g]),
            .full   (lane_full[g])
         );
      end
   endgenerate

   dsk_align_ctrl #(
      .NUM_LANES(NUM_LANES),
      .ERR_LIMIT(ERR_LIMIT)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .all_synced(all_synced),
      .lane_empty(lane_empty),
      .lane_full (lane_full),
      .lane_push (lane_push),
      .head_any  (head_any),
      .head_all  (head_all),
      .aligned   (aligned),
      .capture_en(capture_en),
      .flush     (flush),
      .pop       (pop)
   );

   dsk_out_stage #(
      .NUM_LANES(NUM_LANES)
   ) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (pop),
      .heads    (head_chars),
      .out_data (col_data),
      .out_is_k (col_is_k),
      .out_valid(col_valid)
   );

   assign deskew_ok = aligned;

   // R9
   valid_after_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
      col_valid |-> $past(deskew_ok));

   // R2
   start_on_marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (capture_en && lane_empty[0] && !in_hit[0]) |=> lane_empty[0]);

endmodule

// File: tb/lane_deskew_aligner_bench.sv
module lane_deskew_aligner_bench;

   localparam int NL    = 4;
   localparam int DEPTH = 8;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [NL*8-1:0] rx_data;
   logic [NL-1:0]   rx_is_k;
   logic [NL-1:0]   rx_synced;
   logic [NL*8-1:0] col_data;
   logic [NL-1:0]   col_is_k;
   logic            col_valid;
   logic            deskew_ok;

   always #5 clk = ~clk;

   lane_deskew_aligner u_lane_deskew_aligner (
      .clk      (clk),
      .rst_n    (rst_n),
      .rx_data  (rx_data),
      .rx_is_k  (rx_is_k),
      .rx_synced(rx_synced),
      .col_data (col_data),
      .col_is_k (col_is_k),
      .col_valid(col_valid),
      .deskew_ok(deskew_ok)
   );

   int          n_checks = 0;
   int          n_fail   = 0;
   logic [35:0] exp_q [$];
   logic [8:0]  cols [64][NL];
   int          skew [NL];
   bit          mon_en     = 1'b0;
   bit          first_seen = 1'b0;
   logic        prev_ok    = 1'b0;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic set_all(input int c, input logic k, input logic [7:0] d);
      for (int l = 0; l < NL; l++) cols[c][l] = {k, d};
   endtask

   task automatic set_data(input int c);
      for (int l = 0; l < NL; l++) cols[c][l] = {1'b0, 8'(c * 7 + l * 33 + 5)};
   endtask

   task automatic set_marker(input int c);
      set_all(c, 1'b1, 8'h7C);
   endtask

   task automatic set_partial(input int c);
      set_marker(c);
      cols[c][NL-1] = {1'b0, 8'h11};
   endtask

   function automatic logic [35:0] pack_col(input int c);
      logic [35:0] r;
      r = '0;
      for (int l = 0; l < NL; l++) begin
         r[32 + l]     = cols[c][l][8];
         r[8*l +: 8]   = cols[c][l][7:0];
      end
      return r;
   endfunction

   // driver side of the scoreboard
   task automatic push_exp(input int from, input int to);
      for (int c = from; c <= to; c++) exp_q.push_back(pack_col(c));
   endtask

   task automatic drive_phase(input int n);
      int mx;
      mx = 0;
      for (int l = 0; l < NL; l++) if (skew[l] > mx) mx = skew[l];
      for (int c = 0; c < n + mx; c++) begin
         @(negedge clk);
         for (int l = 0; l < NL; l++) begin
            int idx;
            idx = c - skew[l];
            if (idx >= 0 && idx < n) begin
               rx_is_k[l]       = cols[idx][l][8];
               rx_data[8*l +: 8] = cols[idx][l][7:0];
            end else begin
               rx_is_k[l]       = 1'b0;
               rx_data[8*l +: 8] = 8'h00;
            end
         end
      end
   endtask

   task automatic idle(input int n);
      repeat (n) begin
         @(negedge clk);
         rx_is_k = '0;
         rx_data = '0;
      end
   endtask

   task automatic end_phase(input string req);
      rx_synced = '0;
      idle(3);
      check(exp_q.size() <= DEPTH, req, "columns left unreleased after sync drop",
            64'(exp_q.size()), 64'(DEPTH));
      exp_q.delete();
   endtask

   // monitor side of the scoreboard
   always @(negedge clk) begin
      if (mon_en) begin
         if (col_valid) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R9", "column released with nothing expected",
                     64'({col_is_k, col_data}), 64'(0));
            end else begin
               logic [35:0] e;
               e = exp_q.pop_front();
               check({col_is_k, col_data} == e, "R3", "released column",
                     64'({col_is_k, col_data}), 64'(e));
               if (!first_seen) begin
                  first_seen = 1'b1;
                  check(prev_ok == 1'b1, "R4", "deskew_ok one clock before first column",
                        64'(prev_ok), 64'(1));
               end
            end
         end
         prev_ok = deskew_ok;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL R3 watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      rst_n     = 1'b0;
      rx_data   = '0;
      rx_is_k   = '0;
      rx_synced = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R9 reset state
      check(deskew_ok == 1'b0, "R9", "deskew_ok after reset", 64'(deskew_ok), 64'(0));
      check(col_valid == 1'b0, "R9", "col_valid after reset", 64'(col_valid), 64'(0));
      check(col_data == '0, "R9", "col_data after reset", 64'(col_data), 64'(0));
      check(col_is_k == '0, "R9", "col_is_k after reset", 64'(col_is_k), 64'(0));
      mon_en = 1'b1;

      // R1: lane 3 unsynced, markers everywhere
      rx_synced = 4'b0111;
      repeat (10) begin
         @(negedge clk);
         rx_is_k = '1;
         rx_data = {NL{8'h7C}};
         check(deskew_ok == 1'b0, "R1", "deskew_ok with a lane unsynced", 64'(deskew_ok), 64'(0));
      end
      rx_synced = 4'b1111;
      idle(2);
      check(deskew_ok == 1'b0, "R1", "deskew_ok after markers seen while unsynced",
            64'(deskew_ok), 64'(0));

      // R2: 0x7C without K and other K codes are not markers
      for (int c = 0; c < 6; c++) set_all(c, 1'b0, 8'h7C);
      for (int c = 6; c < 12; c++) set_all(c, 1'b1, 8'hBC);
      skew = '{0, 0, 0, 0};
      drive_phase(12);
      idle(3);
      check(deskew_ok == 1'b0, "R2", "deskew_ok after non-marker codes", 64'(deskew_ok), 64'(0));

      // R3 R4 R5: skew of 6 tolerated, pseudo markers ahead of the real one
      for (int c = 0; c < 4; c++) set_all(c, 1'b0, 8'h7C);
      set_all(4, 1'b1, 8'hBC);
      for (int c = 5; c < 40; c++) set_data(c);
      set_marker(8);
      set_marker(24);
      skew = '{2, 0, 6, 3};
      push_exp(8, 39);
      first_seen = 1'b0;
      drive_phase(40);
      check(deskew_ok == 1'b1, "R5", "deskew_ok with skew of 6", 64'(deskew_ok), 64'(1));
      check(first_seen == 1'b1, "R3", "columns released", 64'(first_seen), 64'(1));

      // R7: one lane loses sync while aligned
      @(negedge clk);
      rx_synced[2] = 1'b0;
      @(negedge clk);
      check(deskew_ok == 1'b0, "R7", "deskew_ok one clock after sync loss", 64'(deskew_ok), 64'(0));
      @(negedge clk);
      check(col_valid == 1'b0, "R7", "col_valid two clocks after sync loss", 64'(col_valid), 64'(0));
      end_phase("R7");

      // R6: skew of 7 with one marker overflows and never aligns
      rx_synced = 4'b1111;
      idle(2);
      for (int c = 0; c < 30; c++) set_data(c);
      set_marker(3);
      skew = '{0, 0, 0, 7};
      first_seen = 1'b0;
      drive_phase(30);
      idle(3);
      check(deskew_ok == 1'b0, "R6", "deskew_ok after skew of 7", 64'(deskew_ok), 64'(0));
      check(first_seen == 1'b0, "R6", "columns released after overflow", 64'(first_seen), 64'(0));

      // R6: hunting continues and a later marker aligns
      for (int c = 0; c < 20; c++) set_data(c);
      set_marker(3);
      skew = '{0, 0, 0, 6};
      push_exp(3, 19);
      drive_phase(20);
      check(deskew_ok == 1'b1, "R6", "realigned on a later marker", 64'(deskew_ok), 64'(1));
      end_phase("R6");

      // R8: error counting and loss of alignment
      rx_synced = 4'b1111;
      idle(2);
      for (int c = 0; c < 30; c++) set_data(c);
      set_marker(3);
      set_partial(7);
      set_partial(8);
      set_partial(9);
      set_marker(11);
      set_partial(13);
      set_partial(14);
      set_partial(16);
      set_partial(17);
      skew = '{1, 3, 0, 2};
      push_exp(3, 17);
      first_seen = 1'b0;
      drive_phase(30);
      idle(3);
      check(exp_q.size() == 0, "R8", "columns up to the fourth error released",
            64'(exp_q.size()), 64'(0));
      check(deskew_ok == 1'b0, "R8", "deskew_ok after four consecutive errors",
            64'(deskew_ok), 64'(0));
      end_phase("R8");

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule